// File: doc/BRIEF.md
# Host-to-ISA I/O Window Bridge

This block sits between a processor's physical address bus and a legacy ISA-style port bus. Each host access is classified as one of three kinds. An access inside an 8 MB I/O window is turned into a 16-bit port address and passed downstream as a single transaction. An access inside a small interrupt-acknowledge window is answered locally. Any other access is a decode miss.

The I/O window has two translations, and a map-mode input selects between them. The dense translation keeps the low 16 address bits. The sparse translation keeps the low five bits and packs one page number per 4 KB page above them. The downstream transaction keeps its access size, its direction and its write data. The bridge waits for the downstream ready signal before it answers the host. A read of the acknowledge slot fetches the vector from the interrupt controller with a single strobe.

The host issues a request only while `host_idle` is high. The answer appears as a one-cycle `host_ack` pulse.

Top module: `isa_io_bridge`

## Requirements
- R1: A request accepted while idle whose address lies in 0x80000000..0x807FFFFF produces exactly one downstream handshake (`io_req` and `io_ready` both high on a clock edge).
- R2: With `map_mode` = 0 the downstream port equals host address bits [15:0].
- R3: With `map_mode` = 1 the downstream port equals address bits [4:0] in port bits [4:0] and address bits [22:12] in port bits [15:5]. Address bits [11:5] do not affect the port.
- R4: The downstream size (0 = byte, 1 = halfword, 2 or 3 = word), the direction `io_we` and, for writes, `io_wdata` equal the host's values. They stay stable while `io_req` waits for ready.
- R5: `io_req` stays high until `io_ready` is sampled high. `host_ack` pulses for one cycle on the cycle after that edge.
- R6: Read data is zero-extended to 32 bits according to size: a byte keeps bits [7:0] and a halfword keeps bits [15:0]. A write response returns 0. `host_rdata` is 0 whenever `host_ack` is low.
- R7: A read at 0xBFFFFFF0 raises `iack_strobe` for exactly one cycle. It then acknowledges the host with the 8-bit `iack_vector` zero-extended, and issues no downstream request.
- R8: Reads at 0xBFFFFFF1..0xBFFFFFF3 return 0 and raise no strobe.
- R9: Writes anywhere in 0xBFFFFFF0..0xBFFFFFF3 are acknowledged, discarded, and raise neither a strobe nor a downstream request.
- R10: Any other address is acknowledged with `host_miss` high and data 0, and is not forwarded.
- R11: `host_req` is ignored while `host_idle` is low. A request held high during a transaction causes no extra transaction.
- R12: After reset the bridge is idle, and `host_ack`, `host_miss`, `io_req` and `iack_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_mode | input | 1 | 0 = dense translation, 1 = sparse translation |
| host_req | input | 1 | Request strobe, taken when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Host physical address |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | 32 | Write data |
| host_idle | output | 1 | Bridge can take a request |
| host_ack | output | 1 | One-cycle response pulse |
| host_miss | output | 1 | Response is a decode miss |
| host_rdata | output | 32 | Response data, valid with host_ack |
| io_req | output | 1 | Downstream request |
| io_we | output | 1 | Downstream direction |
| io_port | output | 16 | Translated port address |
| io_size | output | 2 | Downstream access size |
| io_wdata | output | 32 | Downstream write data |
| io_rdata | input | 32 | Downstream read data |
| io_ready | input | 1 | Downstream completion |
| iack_strobe | output | 1 | Interrupt acknowledge strobe |
| iack_vector | input | 8 | Vector from interrupt controller |

## Verification
The assertions check the handshake rules on every cycle:
- a pending downstream request stays up with a stable port, size and direction until ready;
- the acknowledge strobe lasts one cycle and is followed by the response;
- a miss carries zero data;
- a response never overlaps a pending request or strobe.

Only the bench scenarios can show that the right port value appears for each map mode, that window edges decode correctly, that data is truncated by size, and that a request held during a busy period is ignored.

// File: rtl/isa_bridge_pkg.sv
// Shared types and helpers for the host-to-ISA I/O bridge.
// Assumes a 32-bit host data path.
package isa_bridge_pkg;

    localparam int HOST_DW = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WORD_ALT = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IO_WAIT,
        ST_ACK_FETCH,
        ST_RESPOND
    } bridge_state_e;

    // Keep only the bytes that the access size covers.
    function automatic logic [HOST_DW-1:0] zext_by_size(input logic [HOST_DW-1:0] d,
                                                        input logic [1:0] sz);
        logic [HOST_DW-1:0] r;
        case (sz)
            SZ_BYTE: r = {{(HOST_DW-8){1'b0}}, d[7:0]};
            SZ_HALF: r = {{(HOST_DW-16){1'b0}}, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/isa_window_decode.sv
// Address window decoder: classifies a host address as I/O window,
// acknowledge window or neither. Flags the vector slot of the acknowledge window.
// Assumes both windows are naturally aligned to their power-of-two spans.
module isa_window_decode #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] IO_BASE = 32'h8000_0000,
    parameter int IO_SPAN_LOG2 = 23,
    parameter logic [ADDR_W-1:0] ACK_BASE = 32'hBFFF_FFF0,
    parameter int ACK_SPAN_LOG2 = 2,
    parameter int SLOT_BITS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_io,
    output logic              hit_ack,
    output logic              ack_slot
);
    localparam logic [ADDR_W-IO_SPAN_LOG2-1:0] IO_TAG = IO_BASE[ADDR_W-1:IO_SPAN_LOG2];
    localparam logic [ADDR_W-ACK_SPAN_LOG2-1:0] ACK_TAG = ACK_BASE[ADDR_W-1:ACK_SPAN_LOG2];

    // Compare the upper address bits against each window's tag.
    always_comb begin
        hit_io   = (addr[ADDR_W-1:IO_SPAN_LOG2] == IO_TAG);
        hit_ack  = (addr[ADDR_W-1:ACK_SPAN_LOG2] == ACK_TAG);
        ack_slot = (addr[SLOT_BITS-1:0] == '0);
    end
endmodule

// File: rtl/isa_port_xlate.sv
// Port address translator: dense mode keeps the low address bits; sparse mode
// packs the low offset bits with one page number per 4 KB page.
// Assumes the sparse field widths fit in the port width.
module isa_port_xlate #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    parameter int SPARSE_KEEP = 5,
    parameter int PAGE_LSB = 12,
    parameter int PAGE_MSB = 22
) (
    input  logic              map_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [PORT_W-1:0] port
);
    localparam int PAGE_W   = PAGE_MSB - PAGE_LSB + 1;
    localparam int SPARSE_W = PAGE_W + SPARSE_KEEP;

    logic [PORT_W-1:0] dense_port;
    logic [PORT_W-1:0] sparse_port;

    assign dense_port = addr[PORT_W-1:0];

    generate
        if (SPARSE_W == PORT_W) begin : g_exact
            assign sparse_port = {addr[PAGE_MSB:PAGE_LSB], addr[SPARSE_KEEP-1:0]};
        end else begin : g_pad
            assign sparse_port = {{(PORT_W-SPARSE_W){1'b0}},
                                  addr[PAGE_MSB:PAGE_LSB], addr[SPARSE_KEEP-1:0]};
        end
    endgenerate

    // Select the translation named by the map mode.
    always_comb port = map_mode ? sparse_port : dense_port;
endmodule

// File: rtl/isa_bridge_ctrl.sv
// Transaction controller: accepts one host request at a time, issues the
// downstream access or the acknowledge fetch, and returns a one-cycle response.
// Assumes decode and translation inputs are valid in the cycle host_req is high.
module isa_bridge_ctrl
    import isa_bridge_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [1:0]         host_size,
    input  logic [HOST_DW-1:0] host_wdata,
    input  logic               hit_io,
    input  logic               hit_ack,
    input  logic               ack_slot,
    input  logic [PORT_W-1:0]  xlat_port,
    output logic               host_idle,
    output logic               host_ack,
    output logic               host_miss,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               io_req,
    output logic               io_we,
    output logic [PORT_W-1:0]  io_port,
    output logic [1:0]         io_size,
    output logic [HOST_DW-1:0] io_wdata,
    input  logic [HOST_DW-1:0] io_rdata,
    input  logic               io_ready,
    output logic               iack_strobe,
    input  logic [VEC_W-1:0]   iack_vector
);
    bridge_state_e state;

    assign host_idle = (state == ST_IDLE);

    // Sequence each request through forward, fetch and respond phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            host_ack    <= 1'b0;
            host_miss   <= 1'b0;
            host_rdata  <= '0;
            io_req      <= 1'b0;
            io_we       <= 1'b0;
            io_port     <= '0;
            io_size     <= SZ_BYTE;
            io_wdata    <= '0;
            iack_strobe <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    host_ack   <= 1'b0;
                    host_miss  <= 1'b0;
                    host_rdata <= '0;
                    if (host_req) begin
                        if (hit_io) begin
                            io_req   <= 1'b1;
                            io_we    <= host_we;
                            io_port  <= xlat_port;
                            io_size  <= host_size;
                            io_wdata <= host_we ? host_wdata : '0;
                            state    <= ST_IO_WAIT;
                        end else if (hit_ack) begin
                            if (!host_we && ack_slot) begin
                                iack_strobe <= 1'b1;
                                state       <= ST_ACK_FETCH;
                            end else begin
                                host_ack <= 1'b1;
                                state    <= ST_RESPOND;
                            end
                        end else begin
                            host_ack  <= 1'b1;
                            host_miss <= 1'b1;
                            state     <= ST_RESPOND;
                        end
                    end
                end
                ST_IO_WAIT: begin
                    if (io_ready) begin
                        io_req     <= 1'b0;
                        host_ack   <= 1'b1;
                        host_rdata <= io_we ? '0 : zext_by_size(io_rdata, io_size);
                        state      <= ST_RESPOND;
                    end
                end
                ST_ACK_FETCH: begin
                    iack_strobe <= 1'b0;
                    host_ack    <= 1'b1;
                    host_rdata  <= HOST_DW'(iack_vector);
                    state       <= ST_RESPOND;
                end
                default: begin
                    host_ack   <= 1'b0;
                    host_miss  <= 1'b0;
                    host_rdata <= '0;
                    state      <= ST_IDLE;
                end
            endcase
        end
    end

    // R5
    io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_ready |=> io_req);

    // R4
    io_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req && !io_ready |=> $stable(io_port) && $stable(io_size) && $stable(io_we));

    // R7
    iack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iack_strobe |=> !iack_strobe && host_ack);

    // R10
    miss_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_miss |-> host_ack && host_rdata == '0);

    // R11
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> !io_req && !iack_strobe);

    // R5
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
endmodule

// File: rtl/isa_io_bridge.sv
// Host-to-ISA I/O window bridge top: wires the window decoder and port
// translator into the transaction controller.
// Assumes the host holds address, size and data stable while host_req is high.
module isa_io_bridge #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    parameter int VEC_W = 8,
    parameter logic [ADDR_W-1:0] IO_BASE = 32'h8000_0000,
    parameter int IO_SPAN_LOG2 = 23,
    parameter logic [ADDR_W-1:0] ACK_BASE = 32'hBFFF_FFF0,
    parameter int ACK_SPAN_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_mode,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic              host_idle,
    output logic              host_ack,
    output logic              host_miss,
    output logic [31:0]       host_rdata,
    output logic              io_req,
    output logic              io_we,
    output logic [PORT_W-1:0] io_port,
    output logic [1:0]        io_size,
    output logic [31:0]       io_wdata,
    input  logic [31:0]       io_rdata,
    input  logic              io_ready,
    output logic              iack_strobe,
    input  logic [VEC_W-1:0]  iack_vector
);
    localparam int PAGE_MSB = IO_SPAN_LOG2 - 1;

    logic              hit_io;
    logic              hit_ack;
    logic              ack_slot;
    logic [PORT_W-1:0] xlat_port;

    isa_window_decode #(
        .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_SPAN_LOG2(IO_SPAN_LOG2),
        .ACK_BASE(ACK_BASE), .ACK_SPAN_LOG2(ACK_SPAN_LOG2), .SLOT_BITS(4)
    ) u_decode (
        .addr(host_addr), .hit_io(hit_io), .hit_ack(hit_ack), .ack_slot(ack_slot)
    );

    isa_port_xlate #(
        .ADDR_W(ADDR_W), .PORT_W(PORT_W), .SPARSE_KEEP(5),
        .PAGE_LSB(12), .PAGE_MSB(PAGE_MSB)
    ) u_xlate (
        .map_mode(map_mode), .addr(host_addr), .port(xlat_port)
    );

    isa_bridge_ctrl #(.PORT_W(PORT_W), .VEC_W(VEC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_size(host_size),
        .host_wdata(host_wdata),
        .hit_io(hit_io), .hit_ack(hit_ack), .ack_slot(ack_slot), .xlat_port(xlat_port),
        .host_idle(host_idle), .host_ack(host_ack), .host_miss(host_miss),
        .host_rdata(host_rdata),
        .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_size(io_size),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
        .iack_strobe(iack_strobe), .iack_vector(iack_vector)
    );
endmodule

// File: tb/isa_io_bridge_bench.sv
module isa_io_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_mode = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_idle, host_ack, host_miss;
    logic [31:0] host_rdata;
    logic        io_req, io_we;
    logic [15:0] io_port;
    logic [1:0]  io_size;
    logic [31:0] io_wdata;
    logic [31:0] io_rdata = '0;
    logic        io_ready = 1'b0;
    logic        iack_strobe;
    logic [7:0]  iack_vector = 8'h2B;

    int checks = 0;
    int failures = 0;
    int resp_delay = 0;
    int wait_cnt = 0;
    logic [31:0] resp_data = 32'hA5C3_7E19;
    int fwd_cnt = 0;
    int strobe_cnt = 0;
    logic [15:0] port_seen = '0;

    // reference model state
    int          m_phase = 0;
    logic        m_ack = 0, m_miss = 0, m_io_req = 0, m_strobe = 0, m_we = 0;
    logic [31:0] m_rdata = 0, m_wdata = 0;
    logic [15:0] m_port = 0;
    logic [1:0]  m_size = 0;
    logic        started = 0;

    always #4 clk = ~clk;

    isa_io_bridge u_isa_io_bridge (
        .clk(clk), .rst_n(rst_n), .map_mode(map_mode),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_idle(host_idle), .host_ack(host_ack), .host_miss(host_miss),
        .host_rdata(host_rdata),
        .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_size(io_size),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
        .iack_strobe(iack_strobe), .iack_vector(iack_vector)
    );

    function automatic logic [31:0] trunc(input logic [31:0] d, input logic [1:0] s);
        if (s == 2'd0) return d & 32'hFF;
        if (s == 2'd1) return d & 32'hFFFF;
        return d;
    endfunction

    function automatic logic [15:0] exp_port_of(input logic m, input logic [31:0] a);
        logic [31:0] p;
        if (!m) p = a & 32'hFFFF;
        else    p = (a & 32'h1F) | ((a & 32'h007F_F000) >> 7);
        return p[15:0];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h @%0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model of the bridge, advanced on every clock edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_phase = 0; m_ack = 0; m_miss = 0; m_io_req = 0; m_strobe = 0; m_rdata = 0;
        end else begin
            case (m_phase)
                0: begin
                    m_ack = 0; m_miss = 0; m_rdata = 0;
                    if (host_req) begin
                        if (host_addr >= 32'h8000_0000 && host_addr < 32'h8080_0000) begin
                            m_io_req = 1; m_we = host_we; m_size = host_size;
                            m_port = exp_port_of(map_mode, host_addr);
                            m_wdata = host_wdata; m_phase = 1;
                        end else if (host_addr >= 32'hBFFF_FFF0 && host_addr <= 32'hBFFF_FFF3) begin
                            if (!host_we && host_addr == 32'hBFFF_FFF0) begin
                                m_strobe = 1; m_phase = 2;
                            end else begin
                                m_ack = 1; m_phase = 3;
                            end
                        end else begin
                            m_ack = 1; m_miss = 1; m_phase = 3;
                        end
                    end
                end
                1: if (io_ready) begin
                    m_io_req = 0; m_ack = 1;
                    m_rdata = m_we ? 32'h0 : trunc(io_rdata, m_size);
                    m_phase = 3;
                end
                2: begin
                    m_strobe = 0; m_ack = 1; m_rdata = {24'h0, iack_vector}; m_phase = 3;
                end
                default: begin
                    m_ack = 0; m_miss = 0; m_rdata = 0; m_phase = 0;
                end
            endcase
        end
    end

    // Compare every output with the model between edges.
    always @(negedge clk) begin
        if (started) begin
            chk("R11", "host_idle", 32'(host_idle), 32'(m_phase == 0));
            chk("R5", "host_ack", 32'(host_ack), 32'(m_ack));
            chk("R10", "host_miss", 32'(host_miss), 32'(m_miss));
            chk("R6", "host_rdata", host_rdata, m_rdata);
            chk("R1", "io_req", 32'(io_req), 32'(m_io_req));
            chk("R7", "iack_strobe", 32'(iack_strobe), 32'(m_strobe));
            if (io_req && m_io_req) begin
                chk("R2", "io_port", 32'(io_port), 32'(m_port));
                chk("R4", "io_size", 32'(io_size), 32'(m_size));
                chk("R4", "io_we", 32'(io_we), 32'(m_we));
                if (m_we) chk("R4", "io_wdata", io_wdata, m_wdata);
            end
        end
    end

    // Downstream device: answers after resp_delay cycles.
    always @(negedge clk) begin
        if (io_req && !io_ready) begin
            if (wait_cnt >= resp_delay) begin
                io_ready = 1'b1; io_rdata = resp_data;
            end else wait_cnt++;
        end else if (io_ready) begin
            io_ready = 1'b0; wait_cnt = 0;
        end
    end

    // Count handshakes and strobes.
    always @(posedge clk) begin
        if (io_req && io_ready) begin fwd_cnt++; port_seen = io_port; end
        if (iack_strobe) strobe_cnt++;
    end

    task automatic access(input string req, input logic mode, input logic we,
                          input logic [31:0] addr, input logic [1:0] size,
                          input logic [31:0] wdata, input int delay,
                          input logic [31:0] exp_rdata, input logic exp_miss,
                          input int exp_fwd, input logic [15:0] exp_port,
                          input int exp_strobes);
        @(negedge clk);
        while (!host_idle) @(negedge clk);
        map_mode = mode; resp_delay = delay; fwd_cnt = 0; strobe_cnt = 0;
        host_req = 1'b1; host_we = we; host_addr = addr; host_size = size; host_wdata = wdata;
        @(negedge clk);
        host_req = 1'b0;
        while (!host_ack) @(negedge clk);
        chk(req, "rdata", host_rdata, exp_rdata);
        chk(req, "miss", 32'(host_miss), 32'(exp_miss));
        chk(req, "forward count", fwd_cnt, exp_fwd);
        chk(req, "strobe count", strobe_cnt, exp_strobes);
        if (exp_fwd > 0) chk(req, "port", 32'(port_seen), 32'(exp_port));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "idle", 32'(host_idle), 32'd1);
        chk("R12", "ack", 32'(host_ack), 32'd0);
        chk("R12", "io_req", 32'(io_req), 32'd0);
        chk("R12", "strobe", 32'(iack_strobe), 32'd0);
        rst_n = 1'b1;
        resp_data = 32'hA5C3_7E19;
        // R1 R2 word read, dense mode
        access("R2", 0, 0, 32'h8000_1234, 2'd2, 0, 0, 32'hA5C3_7E19, 0, 1, 16'h1234, 0);
        // R5 R6 byte read with wait states at the window top
        access("R6", 0, 0, 32'h807F_03F8, 2'd0, 0, 3, 32'h0000_0019, 0, 1, 16'h03F8, 0);
        // R6 halfword read
        access("R6", 0, 0, 32'h8000_0060, 2'd1, 0, 1, 32'h0000_7E19, 0, 1, 16'h0060, 0);
        // R4 halfword write returns 0
        access("R4", 0, 1, 32'h8000_0092, 2'd1, 32'h0000_1234, 2, 32'h0, 0, 1, 16'h0092, 0);
        // R3 sparse mode read
        access("R3", 1, 0, 32'h8012_3418, 2'd1, 0, 0, 32'h0000_7E19, 0, 1, 16'h2478, 0);
        // R3 sparse mode top of window, word write
        access("R3", 1, 1, 32'h807F_F01F, 2'd2, 32'hDEAD_BEEF, 4, 32'h0, 0, 1, 16'hFFFF, 0);
        // R3 bits [11:5] dropped
        access("R3", 1, 0, 32'h8000_0FE3, 2'd3, 0, 0, 32'hA5C3_7E19, 0, 1, 16'h0003, 0);
        // R1 window base
        access("R1", 0, 0, 32'h8000_0000, 2'd0, 0, 0, 32'h19, 0, 1, 16'h0000, 0);
        // R7 acknowledge read
        access("R7", 0, 0, 32'hBFFF_FFF0, 2'd2, 0, 0, 32'h0000_002B, 0, 0, 16'h0, 1);
        iack_vector = 8'hF7;
        access("R7", 1, 0, 32'hBFFF_FFF0, 2'd0, 0, 0, 32'h0000_00F7, 0, 0, 16'h0, 1);
        // R8 other acknowledge offsets
        access("R8", 0, 0, 32'hBFFF_FFF2, 2'd0, 0, 0, 32'h0, 0, 0, 16'h0, 0);
        access("R8", 0, 0, 32'hBFFF_FFF3, 2'd0, 0, 0, 32'h0, 0, 0, 16'h0, 0);
        // R9 acknowledge writes
        access("R9", 0, 1, 32'hBFFF_FFF0, 2'd2, 32'h55, 0, 32'h0, 0, 0, 16'h0, 0);
        access("R9", 0, 1, 32'hBFFF_FFF1, 2'd0, 32'h55, 0, 32'h0, 0, 0, 16'h0, 0);
        // R10 misses just outside each window
        access("R10", 0, 0, 32'h8080_0000, 2'd2, 0, 0, 32'h0, 1, 0, 16'h0, 0);
        access("R10", 0, 0, 32'h7FFF_FFFC, 2'd2, 0, 0, 32'h0, 1, 0, 16'h0, 0);
        access("R10", 1, 0, 32'hBFFF_FFF4, 2'd2, 0, 0, 32'h0, 1, 0, 16'h0, 0);
        access("R10", 0, 1, 32'hBFFF_FFEF, 2'd0, 1, 0, 32'h0, 1, 0, 16'h0, 0);
        // R11 request held while busy is ignored
        @(negedge clk);
        while (!host_idle) @(negedge clk);
        map_mode = 0; resp_delay = 6; fwd_cnt = 0; strobe_cnt = 0;
        host_req = 1'b1; host_we = 0; host_addr = 32'h8000_0398; host_size = 2'd0;
        @(negedge clk);
        host_addr = 32'h8000_0010;
        repeat (3) @(negedge clk);
        host_req = 1'b0;
        while (!host_ack) @(negedge clk);
        chk("R11", "forward count", fwd_cnt, 1);
        chk("R11", "port", 32'(port_seen), 32'h0398);
        repeat (4) @(negedge clk);
        chk("R11", "forward count after", fwd_cnt, 1);
        chk("R11", "idle after", 32'(host_idle), 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule